// File: doc/BRIEF.md
# Two-Channel DMA Service Slot Arbiter

This block decides, on every clock, whether a DMA service slot is claimed and which of two channels receives it. Each channel presents a level-sensitive request line together with two control bits taken from its channel control register: an armed bit and a priority bit. A channel competes only when its request line is high and it is armed.

When a slot is granted, the block raises a one-cycle grant pulse and reports the winning channel index. In the same cycle it asserts a stall that takes the processor's execution slot. A channel whose priority bit is set beats one whose bit is clear. When both channels are equal, a rotation bit settles the tie. That bit inverts after every grant, including grants where only one channel was requesting.

All outputs come from registers. Inputs present before a clock edge produce their grant on the outputs right after that edge. Instruction work resumes only in cycles where no grant is issued.

Top module: `dma_slot_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `grant_valid` and `cpu_stall` are 0 after that edge and the rotation bit is cleared to 0.
- R2: A channel is qualified only when both `req_lvl[i]` and `armed[i]` are 1. If no channel is qualified at an edge, `grant_valid` is 0 after that edge.
- R3: When exactly one channel is qualified at an edge, `grant_valid` is 1 after that edge and `grant_channel` holds that channel's index (0 for bit 0, 1 for bit 1).
- R4: When both channels are qualified and exactly one has its `prio` bit at 1, that channel is granted.
- R5: When both channels are qualified and their `prio` bits are equal, the grant goes to channel 0 if the rotation bit is 1 and to channel 1 if it is 0. The first such grant after reset therefore goes to channel 1.
- R6: The rotation bit inverts at every edge that issues a grant, whichever rule chose the channel.
- R7: Requests are level-sensitive. A qualified request held high for N edges yields N consecutive grants, and no grant follows an edge at which it is low.
- R8: `cpu_stall` equals `grant_valid` in every cycle.
- R9: At an edge that issues no grant, the rotation bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lvl | input | 2 | Request levels, bit i for channel i |
| armed | input | 2 | Armed (start) bits from the channel control registers |
| prio | input | 2 | Priority bits from the channel control registers |
| grant_valid | output | 1 | A service slot is granted in this cycle |
| grant_channel | output | 1 | Index of the granted channel, valid while grant_valid is 1 |
| cpu_stall | output | 1 | Processor execution slot taken in this cycle |

## Verification
The embedded assertions check the following on every cycle: the stall always equals the grant, no grant follows an unqualified cycle, a lone qualified channel or a lone priority bit wins, and the rotation bit either flips or holds depending on whether a grant was issued. The rotation bit is not visible at the ports. Its reset value, its flip after a single-requester grant, and its retention across idle cycles can therefore be seen only through the bench's scenarios, which follow such events with a tied request and check which channel wins. Long held requests and reset issued in the middle of traffic are also covered only by bench scenarios.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH   = 2;
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef logic [NUM_CH-1:0]   ch_vec_t;
  typedef logic [CH_IDX_W-1:0] ch_idx_t;

  typedef struct packed {
    logic    valid;
    ch_idx_t chan;
  } grant_t;
endpackage

// File: rtl/dma_req_qualify.sv
module dma_req_qualify
  import dma_arb_pkg::*;
(
  input  ch_vec_t req_lvl,
  input  ch_vec_t armed,
  output ch_vec_t qual
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign qual[g] = req_lvl[g] & armed[g];
  end
endmodule

// File: rtl/dma_pick_resolve.sv
module dma_pick_resolve
  import dma_arb_pkg::*;
(
  input  ch_vec_t qual,
  input  ch_vec_t prio,
  input  logic    rot,
  output grant_t  pick
);
  logic prio_split;

  assign prio_split = prio[0] ^ prio[1];

  always_comb begin
    pick.valid = |qual;
    pick.chan  = '0;
    unique case (qual)
      2'b01: pick.chan = ch_idx_t'(0);
      2'b10: pick.chan = ch_idx_t'(1);
      2'b11: begin
        if (prio_split) pick.chan = prio[1] ? ch_idx_t'(1) : ch_idx_t'(0);
        else            pick.chan = rot     ? ch_idx_t'(0) : ch_idx_t'(1);
      end
      default: pick.chan = '0;
    endcase
  end
endmodule

// File: rtl/dma_rot_state.sv
module dma_rot_state (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic rot
);
  always_ff @(posedge clk) begin
    if (rst)       rot <= 1'b0;
    else if (take) rot <= ~rot;
  end

  // R6
  rot_flip_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (rot != $past(rot)));

  // R9
  rot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rot));
endmodule

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter
  import dma_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   req_lvl,
  input  logic [NUM_CH-1:0]   armed,
  input  logic [NUM_CH-1:0]   prio,
  output logic                grant_valid,
  output logic [CH_IDX_W-1:0] grant_channel,
  output logic                cpu_stall
);
  ch_vec_t qual;
  grant_t  pick;
  logic    rot;

  dma_req_qualify u_qual (
    .req_lvl (req_lvl),
    .armed   (armed),
    .qual    (qual)
  );

  dma_rot_state u_rot (
    .clk  (clk),
    .rst  (rst),
    .take (pick.valid),
    .rot  (rot)
  );

  dma_pick_resolve u_pick (
    .qual (qual),
    .prio (prio),
    .rot  (rot),
    .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid   <= 1'b0;
      cpu_stall     <= 1'b0;
      grant_channel <= '0;
    end else begin
      grant_valid   <= pick.valid;
      cpu_stall     <= pick.valid;
      grant_channel <= pick.chan;
    end
  end

  // R8
  stall_match_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_stall == grant_valid);

  // R2
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(req_lvl & armed) == '0) |-> !grant_valid);

  // R3
  lone_req_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $onehot($past(req_lvl & armed)) |->
      grant_valid && (grant_channel == ($past(req_lvl & armed) == 2'b10)));

  // R4
  prio_win_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(req_lvl & armed) == 2'b11) && $onehot($past(prio)) |->
      grant_valid && (grant_channel == $past(prio[1])));
endmodule

// File: tb/test_dma_slot_arbiter.sv
module test_dma_slot_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req_lvl = '0;
  logic [1:0] armed = '0;
  logic [1:0] prio = '0;
  logic       grant_valid;
  logic       grant_channel;
  logic       cpu_stall;

  int errors = 0;
  int checks = 0;
  bit model_rot = 1'b0;
  bit exp_v_q[$];
  bit exp_c_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dma_slot_arbiter i_dma_slot_arbiter (
    .clk(clk), .rst(rst), .req_lvl(req_lvl), .armed(armed), .prio(prio),
    .grant_valid(grant_valid), .grant_channel(grant_channel), .cpu_stall(cpu_stall)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and queues the expected result.
  task automatic apply(input logic [1:0] r, input logic [1:0] a,
                       input logic [1:0] p, input string tag);
    bit [1:0] q;
    bit v, c;
    @(negedge clk);
    req_lvl = r; armed = a; prio = p;
    q = r & a;
    v = (q != 2'b00);
    c = 1'b0;
    if (q == 2'b10) c = 1'b1;
    else if (q == 2'b11) begin
      if (p[0] != p[1]) c = p[1];
      else              c = !model_rot;
    end
    if (v) model_rot = !model_rot;
    exp_v_q.push_back(v);
    exp_c_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares registered outputs after each edge.
  always @(posedge clk) begin
    #2;
    if (!rst && exp_v_q.size() > 0) begin
      bit v, c;
      string t;
      v = exp_v_q.pop_front();
      c = exp_c_q.pop_front();
      t = tag_q.pop_front();
      check({t, " valid"}, grant_valid, v);
      check("R8 stall", cpu_stall, grant_valid);
      if (v) check({t, " channel"}, grant_channel, c);
    end
  end

  task automatic do_reset();
    apply(2'b00, 2'b00, 2'b00, "R2 idle");
    while (exp_v_q.size() > 0) @(negedge clk);
    rst = 1'b1;
    model_rot = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 valid", grant_valid, 0);
    check("R1 stall", cpu_stall, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", grant_valid, 0);
    check("R1 stall", cpu_stall, 0);
    rst = 1'b0;
    // R5: first tie after reset goes to channel 1
    apply(2'b11, 2'b11, 2'b00, "R5 tie first");
    apply(2'b11, 2'b11, 2'b11, "R5 tie second");
    apply(2'b11, 2'b11, 2'b00, "R5 tie third");
    // R2: unarmed requests ignored
    apply(2'b11, 2'b00, 2'b00, "R2 unarmed");
    apply(2'b01, 2'b10, 2'b00, "R2 mismatch");
    apply(2'b00, 2'b11, 2'b11, "R2 armed only");
    // R3 single requesters; R6 rot flips on them
    apply(2'b01, 2'b11, 2'b10, "R3 ch0 alone");
    apply(2'b10, 2'b11, 2'b01, "R3 ch1 alone");
    apply(2'b11, 2'b01, 2'b00, "R3 ch0 armed");
    apply(2'b11, 2'b11, 2'b00, "R6 tie after single");
    // R4 priority
    apply(2'b11, 2'b11, 2'b01, "R4 ch0 prio");
    apply(2'b11, 2'b11, 2'b10, "R4 ch1 prio");
    apply(2'b11, 2'b11, 2'b01, "R4 ch0 prio again");
    // R9 rotation holds across idle cycles
    apply(2'b01, 2'b01, 2'b00, "R6 single");
    for (int i = 0; i < 3; i++) apply(2'b00, 2'b11, 2'b00, "R9 idle");
    apply(2'b11, 2'b11, 2'b11, "R9 tie after idle");
    // R7 held level gives one grant per edge, none after drop
    for (int i = 0; i < 6; i++) apply(2'b10, 2'b11, 2'b00, "R7 held");
    apply(2'b00, 2'b11, 2'b00, "R7 dropped");
    apply(2'b11, 2'b11, 2'b00, "R7 tie after run");
    // R1 reset mid-stream restores rotation to 0
    apply(2'b01, 2'b11, 2'b00, "R6 single pre-reset");
    do_reset();
    apply(2'b11, 2'b11, 2'b00, "R1 R5 tie after reset");
    apply(2'b00, 2'b00, 2'b00, "R2 idle end");
    while (exp_v_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule